// File: doc/BRIEF.md
# Per-Channel Companding Sample Converter

This block sits in a time-division multiplexed voice data path and converts one channel sample at a time between the 8-bit companded form used on the line and the 16-bit linear form kept in memory. It has two independent directions. The receive direction expands a companded byte into a linear PCM sample. An A-law sample is 13 bits and a µ-law sample is 14 bits. Either one is left-aligned in a 16-bit word, with zeros filling the bits to its right. The transmit direction takes such a left-aligned 16-bit word and compresses its upper bits back into one companded byte.

Every item carries a mode tag with it, so the conversion can change from one channel to the next. The mode tag selects A-law, µ-law or transparent pass-through. Receive and transmit items are tagged separately, so the two directions need not use the same law. A companded channel takes 16 bits of buffer for every 8 line bits, and a pass-through channel takes 8. The receive output carries a flag that marks the double-width items, so that the buffer side can size each one.

Each direction is a valid/ready stream with one register stage. Backpressure from the output propagates to the input in the same cycle.

Top module: `pcm_compander`

## Requirements
- R1: Receive, mode 1 (A-law): the output word is the G.711 A-law expansion of the byte after even-bit inversion (XOR 0x55). It is a 13-bit signed sample in bits 15:3, and bits 2:0 are zero. Examples: 0xD5 gives 0x0008, 0xAA gives 0x7E00, 0x2A gives 0x8200.
- R2: Receive, mode 2 (µ-law): the output word is the G.711 µ-law expansion of the bit-inverted byte. It is a 14-bit signed sample in bits 15:2, and bits 1:0 are zero. Examples: 0xFF gives 0x0000, 0x80 gives 0x7D7C, 0x00 gives 0x8284.
- R3: Transmit, mode 1 (A-law): the output code is the A-law compression of word bits 15:3, XORed with 0x55, and word bits 2:0 have no effect. Examples: 0x0000 and 0x0007 give 0xD5, 0x7FFF gives 0xAA, 0x8000 gives 0x2A.
- R4: Transmit, mode 2 (µ-law): the output code is the µ-law compression of word bits 15:2, and word bits 1:0 have no effect. The magnitude is clipped at 8159, then a bias of 33 is added before the segment search, and the code is bit-inverted. A biased magnitude beyond the top segment gives the largest-magnitude code with its sign. Examples: 0x0000 and 0x0003 give 0xFF, 0x7FFF gives 0x80, 0x8000 gives 0x00.
- R5: In both companded transmit modes, code bit 7 is the inverse of word bit 15, so the sign is preserved.
- R6: Modes 0 and 3 are pass-through. A receive byte appears unchanged in bits 7:0, with bits 15:8 zero. A transmit code is word bits 7:0.
- R7: The receive flag rx_out_wide is 1 for items converted in mode 1 or 2, and 0 for pass-through items.
- R8: Each output item carries the mode tag of the input item it came from. Each item is converted by its own tag, independently in the two directions.
- R9: An item accepted on a clock edge (valid and ready both high) appears at the output valid after that edge, one cycle of latency.
- R10: While an output is valid and not ready, the output valid, data and tag hold unchanged and the input ready is low. No item is lost or duplicated, and with the output ready high the stage accepts an item every cycle.
- R11: After reset both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in_valid | input | 1 | Receive input item valid |
| rx_in_ready | output | 1 | Receive input can accept |
| rx_in_mode | input | MODE_W (2) | Receive item mode: 0 pass, 1 A-law, 2 µ-law, 3 pass |
| rx_in_code | input | CODE_W (8) | Companded byte from the line |
| rx_out_valid | output | 1 | Receive output item valid |
| rx_out_ready | input | 1 | Receive output consumer ready |
| rx_out_mode | output | MODE_W (2) | Mode tag of the receive output item |
| rx_out_word | output | WORD_W (16) | Expanded left-aligned sample or passed byte |
| rx_out_wide | output | 1 | Item occupies 16 bits per 8 line bits |
| tx_in_valid | input | 1 | Transmit input item valid |
| tx_in_ready | output | 1 | Transmit input can accept |
| tx_in_mode | input | MODE_W (2) | Transmit item mode, same encoding as receive |
| tx_in_word | input | WORD_W (16) | Left-aligned linear word from memory |
| tx_out_valid | output | 1 | Transmit output item valid |
| tx_out_ready | input | 1 | Transmit output consumer ready |
| tx_out_mode | output | MODE_W (2) | Mode tag of the transmit output item |
| tx_out_code | output | CODE_W (8) | Companded or passed byte for the line |

## Verification
The bench builds the block with its default parameters: 8-bit codes, 16-bit words and a 2-bit mode tag. With these values every one of the 256 codes can be swept under all four tags, and the reserved tag value 3 can be driven. The receive direction is swept exhaustively with random output stalls. The transmit direction gets random words together with the extreme values that reach µ-law clipping, saturation and the ignored low bits. Both directions run at once with unrelated tags, and a behavioural model compares the result every cycle.

// File: rtl/pcm_compand_pkg.sv
package pcm_compand_pkg;
   typedef enum logic [1:0] {
      MODE_PASS = 2'd0,
      MODE_ALAW = 2'd1,
      MODE_ULAW = 2'd2,
      MODE_RSVD = 2'd3
   } cmode_e;

   localparam int LAW_A = 0;
   localparam int LAW_U = 1;

   localparam logic [7:0]  ALAW_XOR   = 8'h55;
   localparam logic [15:0] U_BIAS_EXP = 16'h0084;
   localparam logic [13:0] U_CLIP     = 14'd8159;
   localparam logic [13:0] U_BIAS_CMP = 14'd33;

   localparam int A_PAD = 3;
   localparam int U_PAD = 2;
endpackage

// File: rtl/pcm_stream_stage.sv
module pcm_stream_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("pcm_stream_stage: DATA_W must be positive");
   end

   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (in_ready) out_valid <= in_valid;
         if (take)     out_data  <= in_data;
      end
   end

   // R9
   accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pcm_expander.sv
module pcm_expander
   import pcm_compand_pkg::*;
#(
   parameter int LAW    = LAW_A,
   parameter int CODE_W = 8,
   parameter int WORD_W = 16
) (
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] lin
);
   if (CODE_W != 8 || WORD_W != 16) begin : g_bad_width
      $error("pcm_expander: only 8-bit codes and 16-bit words");
   end

   if (LAW == LAW_A) begin : g_alaw
      logic [7:0]  flip;
      logic [15:0] mag;
      assign flip = code ^ ALAW_XOR;
      always_comb begin
         if (flip[6:4] == 3'd0)
            mag = {8'd0, flip[3:0], 4'h8};
         else
            mag = ({8'd0, flip[3:0], 4'h0} + 16'h0108) << (flip[6:4] - 3'd1);
      end
      assign lin = flip[7] ? mag : (16'd0 - mag);
   end else begin : g_ulaw
      logic [7:0]  inv;
      logic [15:0] mag;
      assign inv = ~code;
      assign mag = ({9'd0, inv[3:0], 3'b000} + U_BIAS_EXP) << inv[6:4];
      assign lin = inv[7] ? (U_BIAS_EXP - mag) : (mag - U_BIAS_EXP);
   end
endmodule

// File: rtl/pcm_compressor.sv
module pcm_compressor
   import pcm_compand_pkg::*;
#(
   parameter int LAW    = LAW_A,
   parameter int CODE_W = 8,
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] lin,
   output logic [CODE_W-1:0] code
);
   if (CODE_W != 8 || WORD_W != 16) begin : g_bad_width
      $error("pcm_compressor: only 8-bit codes and 16-bit words");
   end

   if (LAW == LAW_A) begin : g_alaw
      logic        neg;
      logic [11:0] mag;
      logic [2:0]  seg;
      logic [3:0]  mant;
      logic [2:0]  unused_lsb;

      assign neg        = lin[15];
      assign unused_lsb = lin[2:0];
      assign mag        = neg ? ~lin[14:3] : lin[14:3];

      always_comb begin
         seg = '0;
         for (int i = 5; i < 12; i++)
            if (mag[i]) seg = 3'(i - 4);
      end

      assign mant = (seg < 3'd2) ? mag[4:1] : 4'(mag >> seg);
      assign code = {1'b0, seg, mant} ^ (neg ? ALAW_XOR : (ALAW_XOR | 8'h80));
   end else begin : g_ulaw
      logic        neg;
      logic [13:0] smp;
      logic [13:0] mag;
      logic [13:0] clip;
      logic [13:0] biased;
      logic [13:0] shifted;
      logic [3:0]  seg;
      logic [6:0]  body;
      logic [1:0]  unused_lsb;

      assign neg        = lin[15];
      assign smp        = lin[15:2];
      assign unused_lsb = lin[1:0];
      assign mag        = neg ? (~smp + 14'd1) : smp;
      assign clip       = (mag > U_CLIP) ? U_CLIP : mag;
      assign biased     = clip + U_BIAS_CMP;

      always_comb begin
         seg = '0;
         for (int i = 6; i < 14; i++)
            if (biased[i]) seg = 4'(i - 5);
      end

      assign shifted = biased >> (seg + 4'd1);
      assign body    = seg[3] ? 7'h7F : {seg[2:0], shifted[3:0]};
      assign code    = {1'b0, body} ^ (neg ? 8'h7F : 8'hFF);
   end
endmodule

// File: rtl/pcm_compander.sv
module pcm_compander
   import pcm_compand_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int WORD_W = 16,
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in_valid,
   output logic              rx_in_ready,
   input  logic [MODE_W-1:0] rx_in_mode,
   input  logic [CODE_W-1:0] rx_in_code,
   output logic              rx_out_valid,
   input  logic              rx_out_ready,
   output logic [MODE_W-1:0] rx_out_mode,
   output logic [WORD_W-1:0] rx_out_word,
   output logic              rx_out_wide,
   input  logic              tx_in_valid,
   output logic              tx_in_ready,
   input  logic [MODE_W-1:0] tx_in_mode,
   input  logic [WORD_W-1:0] tx_in_word,
   output logic              tx_out_valid,
   input  logic              tx_out_ready,
   output logic [MODE_W-1:0] tx_out_mode,
   output logic [CODE_W-1:0] tx_out_code
);
   localparam int RX_DATA_W = MODE_W + 1 + WORD_W;
   localparam int TX_DATA_W = MODE_W + CODE_W;
   localparam int PAD_W     = WORD_W - CODE_W;

   if (CODE_W != 8)  begin : g_bad_code $error("pcm_compander: CODE_W must be 8");  end
   if (WORD_W != 16) begin : g_bad_word $error("pcm_compander: WORD_W must be 16"); end
   if (MODE_W < 2)   begin : g_bad_mode $error("pcm_compander: MODE_W must be >= 2"); end

   localparam logic [MODE_W-1:0] M_A = MODE_W'(MODE_ALAW);
   localparam logic [MODE_W-1:0] M_U = MODE_W'(MODE_ULAW);

   // receive: expand
   logic [WORD_W-1:0] rx_a_lin, rx_u_lin, rx_word;
   logic              rx_wide;

   pcm_expander #(.LAW(LAW_A), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_rx_alaw (
      .code(rx_in_code), .lin(rx_a_lin));
   pcm_expander #(.LAW(LAW_U), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_rx_ulaw (
      .code(rx_in_code), .lin(rx_u_lin));

   always_comb begin
      if (rx_in_mode == M_A) begin
         rx_word = rx_a_lin;
         rx_wide = 1'b1;
      end else if (rx_in_mode == M_U) begin
         rx_word = rx_u_lin;
         rx_wide = 1'b1;
      end else begin
         rx_word = {{PAD_W{1'b0}}, rx_in_code};
         rx_wide = 1'b0;
      end
   end

   pcm_stream_stage #(.DATA_W(RX_DATA_W)) u_rx_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_in_valid),
      .in_ready (rx_in_ready),
      .in_data  ({rx_in_mode, rx_wide, rx_word}),
      .out_valid(rx_out_valid),
      .out_ready(rx_out_ready),
      .out_data ({rx_out_mode, rx_out_wide, rx_out_word})
   );

   // transmit: compress
   logic [CODE_W-1:0] tx_a_code, tx_u_code, tx_code;

   pcm_compressor #(.LAW(LAW_A), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_tx_alaw (
      .lin(tx_in_word), .code(tx_a_code));
   pcm_compressor #(.LAW(LAW_U), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_tx_ulaw (
      .lin(tx_in_word), .code(tx_u_code));

   always_comb begin
      if (tx_in_mode == M_A)      tx_code = tx_a_code;
      else if (tx_in_mode == M_U) tx_code = tx_u_code;
      else                        tx_code = tx_in_word[CODE_W-1:0];
   end

   pcm_stream_stage #(.DATA_W(TX_DATA_W)) u_tx_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (tx_in_valid),
      .in_ready (tx_in_ready),
      .in_data  ({tx_in_mode, tx_code}),
      .out_valid(tx_out_valid),
      .out_ready(tx_out_ready),
      .out_data ({tx_out_mode, tx_out_code})
   );

   // R1
   rx_alaw_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_valid && rx_out_mode == M_A) |-> (rx_out_word[A_PAD-1:0] == '0));

   // R2
   rx_ulaw_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_valid && rx_out_mode == M_U) |-> (rx_out_word[U_PAD-1:0] == '0));

   // R6
   rx_pass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_valid && !rx_out_wide) |-> (rx_out_word[WORD_W-1:CODE_W] == '0));

   // R7
   rx_wide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out_valid |-> (rx_out_wide == (rx_out_mode == M_A || rx_out_mode == M_U)));

   // R5
   tx_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_in_valid && tx_in_ready && (tx_in_mode == M_A || tx_in_mode == M_U))
      |=> (tx_out_code[CODE_W-1] == !$past(tx_in_word[WORD_W-1])));

   // R8
   rx_tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_in_valid && rx_in_ready) |=> (rx_out_mode == $past(rx_in_mode)));

   // R8
   tx_tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_in_valid && tx_in_ready) |=> (tx_out_mode == $past(tx_in_mode)));
endmodule

// File: tb/tb_pcm_compander.sv
`timescale 1ns/1ps
module tb_pcm_compander;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_in_valid = 1'b0, rx_out_ready = 1'b0;
   logic [1:0]  rx_in_mode = 2'd0;
   logic [7:0]  rx_in_code = 8'd0;
   logic        tx_in_valid = 1'b0, tx_out_ready = 1'b0;
   logic [1:0]  tx_in_mode = 2'd0;
   logic [15:0] tx_in_word = 16'd0;
   logic        rx_in_ready, rx_out_valid, rx_out_wide;
   logic [1:0]  rx_out_mode, tx_out_mode;
   logic [15:0] rx_out_word;
   logic        tx_in_ready, tx_out_valid;
   logic [7:0]  tx_out_code;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #5 clk = ~clk;

   pcm_compander dut (
      .clk(clk), .rst_n(rst_n),
      .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
      .rx_in_mode(rx_in_mode), .rx_in_code(rx_in_code),
      .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
      .rx_out_mode(rx_out_mode), .rx_out_word(rx_out_word), .rx_out_wide(rx_out_wide),
      .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
      .tx_in_mode(tx_in_mode), .tx_in_word(tx_in_word),
      .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
      .tx_out_mode(tx_out_mode), .tx_out_code(tx_out_code)
   );

   // behavioural conversion references
   function automatic int ref_a_exp(int b);
      int a, t, sg;
      a  = (b ^ 'h55) & 255;
      t  = (a & 15) << 4;
      sg = (a >> 4) & 7;
      if (sg == 0)      t = t + 8;
      else if (sg == 1) t = t + 264;
      else              t = (t + 264) << (sg - 1);
      return ((a & 128) != 0 ? t : -t) & 'hFFFF;
   endfunction

   function automatic int ref_u_exp(int b);
      int u, t;
      u = (~b) & 255;
      t = (((u & 15) << 3) + 132) << ((u >> 4) & 7);
      return ((u & 128) != 0 ? 132 - t : t - 132) & 'hFFFF;
   endfunction

   function automatic int ref_a_cmp(int w);
      int v, mask, seg, r;
      v = (w >= 32768) ? w - 65536 : w;
      v = v >>> 3;
      if (v < 0) begin v = -v - 1; mask = 'h55; end
      else mask = 'hD5;
      seg = 0;
      while (seg < 8 && v > ((32 << seg) - 1)) seg++;
      if (seg >= 8) r = 'h7F;
      else r = (seg << 4) | (((seg < 2) ? (v >> 1) : (v >> seg)) & 15);
      return (r ^ mask) & 255;
   endfunction

   function automatic int ref_u_cmp(int w);
      int v, mask, seg, r;
      v = (w >= 32768) ? w - 65536 : w;
      v = v >>> 2;
      if (v < 0) begin v = -v; mask = 'h7F; end
      else mask = 'hFF;
      if (v > 8159) v = 8159;
      v = v + 33;
      seg = 0;
      while (seg < 8 && v > ((64 << seg) - 1)) seg++;
      if (seg >= 8) r = 'h7F;
      else r = (seg << 4) | ((v >> (seg + 1)) & 15);
      return (r ^ mask) & 255;
   endfunction

   // cycle model state
   bit m_rx_v, m_tx_v, m_rx_wide;
   int m_rx_word, m_rx_mode, m_tx_code, m_tx_mode;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rx_v = 1'b0;
         m_tx_v = 1'b0;
      end else begin
         if (!m_rx_v || rx_out_ready) begin
            m_rx_v = rx_in_valid;
            if (rx_in_valid) begin
               m_rx_mode = int'(rx_in_mode);
               case (rx_in_mode)
                  2'd1:    begin m_rx_word = ref_a_exp(int'(rx_in_code)); m_rx_wide = 1'b1; end
                  2'd2:    begin m_rx_word = ref_u_exp(int'(rx_in_code)); m_rx_wide = 1'b1; end
                  default: begin m_rx_word = int'(rx_in_code);            m_rx_wide = 1'b0; end
               endcase
            end
         end
         if (!m_tx_v || tx_out_ready) begin
            m_tx_v = tx_in_valid;
            if (tx_in_valid) begin
               m_tx_mode = int'(tx_in_mode);
               case (tx_in_mode)
                  2'd1:    m_tx_code = ref_a_cmp(int'(tx_in_word));
                  2'd2:    m_tx_code = ref_u_cmp(int'(tx_in_word));
                  default: m_tx_code = int'(tx_in_word) & 255;
               endcase
            end
         end
      end
   end

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string rx_tag(int m);
      return (m == 1) ? "R1" : (m == 2) ? "R2" : "R6";
   endfunction

   function automatic string tx_tag(int m);
      return (m == 1) ? "R3" : (m == 2) ? "R4" : "R6";
   endfunction

   task automatic compare_all();
      bit er, et;
      er = !m_rx_v || rx_out_ready;
      et = !m_tx_v || tx_out_ready;
      chk("R9 rx valid", rx_out_valid == m_rx_v, int'(rx_out_valid), int'(m_rx_v));
      chk("R9 tx valid", tx_out_valid == m_tx_v, int'(tx_out_valid), int'(m_tx_v));
      chk("R10 rx ready", rx_in_ready == er, int'(rx_in_ready), int'(er));
      chk("R10 tx ready", tx_in_ready == et, int'(tx_in_ready), int'(et));
      if (m_rx_v && rx_out_valid) begin
         chk(rx_tag(m_rx_mode), int'(rx_out_word) == m_rx_word, int'(rx_out_word), m_rx_word);
         chk("R8 rx mode", int'(rx_out_mode) == m_rx_mode, int'(rx_out_mode), m_rx_mode);
         chk("R7 rx wide", rx_out_wide == m_rx_wide, int'(rx_out_wide), int'(m_rx_wide));
      end
      if (m_tx_v && tx_out_valid) begin
         chk(tx_tag(m_tx_mode), int'(tx_out_code) == m_tx_code, int'(tx_out_code), m_tx_code);
         chk("R8 tx mode", int'(tx_out_mode) == m_tx_mode, int'(tx_out_mode), m_tx_mode);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (cmp_on) compare_all();
   endtask

   task automatic rx_one(input string tag, input logic [1:0] md, input logic [7:0] cd,
                         input int exp);
      rx_in_valid = 1'b1; rx_in_mode = md; rx_in_code = cd; rx_out_ready = 1'b1;
      step();
      rx_in_valid = 1'b0;
      chk(tag, rx_out_valid && int'(rx_out_word) == exp, int'(rx_out_word), exp);
   endtask

   task automatic tx_one(input string tag, input logic [1:0] md, input logic [15:0] wd,
                         input int exp);
      tx_in_valid = 1'b1; tx_in_mode = md; tx_in_word = wd; tx_out_ready = 1'b1;
      step();
      tx_in_valid = 1'b0;
      chk(tag, tx_out_valid && int'(tx_out_code) == exp, int'(tx_out_code), exp);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk("R9 watchdog", 1'b0, 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 rx valid", rx_out_valid == 1'b0, int'(rx_out_valid), 0);
      chk("R11 tx valid", tx_out_valid == 1'b0, int'(tx_out_valid), 0);
      chk("R11 rx ready", rx_in_ready == 1'b1, int'(rx_in_ready), 1);
      chk("R11 tx ready", tx_in_ready == 1'b1, int'(tx_in_ready), 1);
      cmp_on = 1'b1;

      // R1 A-law expansion
      rx_one("R1 d5", 2'd1, 8'hD5, 'h0008);
      rx_one("R1 aa", 2'd1, 8'hAA, 'h7E00);
      rx_one("R1 2a", 2'd1, 8'h2A, 'h8200);
      chk("R7 wide alaw", rx_out_wide == 1'b1, int'(rx_out_wide), 1);
      // R2 mu-law expansion
      rx_one("R2 ff", 2'd2, 8'hFF, 'h0000);
      rx_one("R2 80", 2'd2, 8'h80, 'h7D7C);
      rx_one("R2 00", 2'd2, 8'h00, 'h8284);
      // R6 pass-through, both pass codes
      rx_one("R6 pass", 2'd0, 8'h5A, 'h005A);
      chk("R7 wide pass", rx_out_wide == 1'b0, int'(rx_out_wide), 0);
      rx_one("R6 rsvd", 2'd3, 8'hC3, 'h00C3);
      // R3 A-law compression, low bits ignored
      tx_one("R3 zero", 2'd1, 16'h0000, 'hD5);
      tx_one("R3 lsb", 2'd1, 16'h0007, 'hD5);
      tx_one("R3 max", 2'd1, 16'h7FFF, 'hAA);
      tx_one("R3 min", 2'd1, 16'h8000, 'h2A);
      chk("R5 alaw sign", tx_out_code[7] == 1'b0, int'(tx_out_code[7]), 0);
      // R4 mu-law compression, clip and saturation
      tx_one("R4 zero", 2'd2, 16'h0000, 'hFF);
      tx_one("R4 lsb", 2'd2, 16'h0003, 'hFF);
      tx_one("R4 satp", 2'd2, 16'h7FFF, 'h80);
      chk("R5 ulaw sign", tx_out_code[7] == 1'b1, int'(tx_out_code[7]), 1);
      tx_one("R4 satn", 2'd2, 16'h8000, 'h00);
      tx_one("R6 txpass", 2'd0, 16'h1234, 'h34);
      tx_one("R6 txrsvd", 2'd3, 16'hABCD, 'hCD);

      // R10 backpressure hold, then R9 no loss
      step();
      rx_out_ready = 1'b0;
      rx_in_valid = 1'b1; rx_in_mode = 2'd1; rx_in_code = 8'hD5;
      step();
      rx_in_code = 8'hAA;
      step();
      chk("R10 hold word", rx_out_valid && rx_out_word == 16'h0008, int'(rx_out_word), 'h0008);
      chk("R10 ready low", rx_in_ready == 1'b0, int'(rx_in_ready), 0);
      step();
      chk("R10 still held", rx_out_word == 16'h0008, int'(rx_out_word), 'h0008);
      rx_out_ready = 1'b1;
      step();
      chk("R9 next item", rx_out_valid && rx_out_word == 16'h7E00, int'(rx_out_word), 'h7E00);
      rx_in_valid = 1'b0;
      step();
      chk("R10 drained", rx_out_valid == 1'b0, int'(rx_out_valid), 0);

      // R8 exhaustive receive sweep with independent transmit traffic
      for (int i = 0; i < 1024; i++) begin
         rx_in_valid  = 1'b1;
         rx_in_code   = 8'(i);
         rx_in_mode   = 2'(i >> 8);
         rx_out_ready = 1'b1;
         tx_in_valid  = 1'b1;
         tx_in_mode   = 2'($urandom_range(0, 3));
         tx_in_word   = 16'($urandom);
         tx_out_ready = ($urandom_range(0, 3) != 0);
         step();
      end

      // random stalls on both directions, boundary words mixed in
      for (int i = 0; i < 4000; i++) begin
         rx_in_valid  = ($urandom_range(0, 3) != 0);
         rx_in_mode   = 2'($urandom_range(0, 3));
         rx_in_code   = 8'($urandom);
         rx_out_ready = ($urandom_range(0, 2) != 0);
         tx_in_valid  = ($urandom_range(0, 3) != 0);
         tx_in_mode   = 2'($urandom_range(0, 3));
         case ($urandom_range(0, 7))
            0:       tx_in_word = 16'h7FFF;
            1:       tx_in_word = 16'h8000;
            2:       tx_in_word = 16'(16'h7F7C + $urandom_range(0, 255));
            3:       tx_in_word = 16'(16'h8000 + $urandom_range(0, 255));
            default: tx_in_word = 16'($urandom);
         endcase
         tx_out_ready = ($urandom_range(0, 2) != 0);
         step();
      end

      rx_in_valid = 1'b0;
      tx_in_valid = 1'b0;
      rx_out_ready = 1'b1;
      tx_out_ready = 1'b1;
      repeat (3) step();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule